// File: doc/BRIEF.md
# Variable-Length Group Prefix Stream Parser

The parser sits in an instruction fetch path that moves one 16-bit parcel per cycle under a valid/ready handshake. Parcels flow straight through with no added latency. Beside each parcel the parser emits a classification tag. Most parcels are ordinary instructions. When a parcel outside a group has its low seven bits all set, it opens a group. That header parcel states how long the group is and which optional sub-blocks follow it.

Once a group is open, the parser counts parcels to find the parts in their fixed order. First comes an optional vector-length block, then up to three register-remap entries, then up to three predicate-remap entries, and last the payload instructions. The parser keeps the vector length, maximum vector length and sub-vector length taken from the vector-length block. It reports when a group is active, pulses a marker when the group closes, and flags two errors: a malformed header, and a header whose sub-blocks leave no room for payload.

Downstream logic uses the tag stream to send header, remap and payload parcels to the right consumers. It uses the group-end pulse to drop the remap context when the group closes.

Top module: `vliw_grp_parser`

## Requirements
- R1: Outside a group, a parcel whose bits 6:0 are not 1111111 passes through with the same data and is tagged INSN (code 0). out_valid follows in_valid and in_ready follows out_ready in the same cycle.
- R2: Outside a group, a parcel with bits 6:0 = 1111111, bit 15 = 0 and bits 14:12 not equal to 111 is tagged HDR (code 1) and opens a group. grp_active is high from the next cycle on.
- R3: A group has exactly 5 + IL parcels, counting the header, where IL is header bits 14:12. grp_active falls, and grp_end is high for exactly one cycle, in the cycle right after the last parcel of the group is transferred.
- R4: When header bit 7 is set, the parcel right after the header is tagged VLB (code 2). From the cycle after it is transferred, vl_len shows its bits 5:0, vl_max its bits 11:6 and vl_sub its bits 14:12.
- R5: Header bits 9:8 give the number of parcels (0 to 3) tagged REGCAM (code 3). They follow the vector-length block, or follow the header when there is no such block.
- R6: Header bits 11:10 give the number of parcels (0 to 3) tagged PREDCAM (code 4). They follow the REGCAM parcels.
- R7: All remaining parcels of the group are tagged PAY (code 5). A parcel inside a group whose bits 6:0 are 1111111 is payload and does not open a new group.
- R8: A prefix parcel outside a group with IL = 111 or bit 15 set is tagged HDR but opens no group. err_hdr is high for one cycle in the next cycle, and the next parcel is classified as if outside a group.
- R9: When 1 + (bit 7) + (bits 9:8) + (bits 11:10) is at least 5 + IL, err_nopay is high for one cycle in the cycle after the header. The group still takes exactly 5 + IL parcels, tagged in the fixed order and cut off at the group length.
- R10: While out_ready is low, no parcel is transferred, in_ready is low, and the group position does not advance. The parcel held at the input keeps the same tag until it is transferred.
- R11: vl_len, vl_max and vl_sub read zero from the cycle in which grp_end is high. They keep their values until the next vector-length block is transferred.
- R12: After reset, grp_active, grp_end, err_hdr, err_nopay and the three vector-length outputs are zero, and the parser is outside any group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input parcel valid |
| in_ready | output | 1 | Parser can take the input parcel |
| in_data | input | 16 | Input parcel |
| out_valid | output | 1 | Output parcel valid |
| out_ready | input | 1 | Consumer can take the output parcel |
| out_data | output | 16 | Output parcel |
| out_tag | output | 3 | Parcel class: 0 INSN, 1 HDR, 2 VLB, 3 REGCAM, 4 PREDCAM, 5 PAY |
| grp_active | output | 1 | A group is open |
| grp_end | output | 1 | One-cycle pulse after the last parcel of a group |
| err_hdr | output | 1 | One-cycle pulse for a malformed prefix |
| err_nopay | output | 1 | One-cycle pulse for a group with no payload room |
| vl_len | output | 6 | Latched vector length |
| vl_max | output | 6 | Latched maximum vector length |
| vl_sub | output | 3 | Latched sub-vector length |

## Verification
Assertions check on every cycle that the group position stays inside the group length and freezes while the output is stalled. They also check that grp_end goes with the fall of grp_active, that an error pulse never coincides with the wrong group state, and that the latched lengths change only on a load or a clear. Only the bench scenarios can show that the tag order is right for a given header, that a group has exactly 5 + IL parcels, that the latched fields come from the right bit positions, and that prefix-looking payload and malformed headers are handled as required.

// File: rtl/prs_pkg.sv
package prs_pkg;
   typedef enum logic [2:0] {
      TAG_INSN = 3'd0,
      TAG_HDR  = 3'd1,
      TAG_VLB  = 3'd2,
      TAG_REG  = 3'd3,
      TAG_PRED = 3'd4,
      TAG_PAY  = 3'd5
   } ptag_e;
endpackage

// File: rtl/prs_hdr_dec.sv
module prs_hdr_dec #(
   parameter int PW        = 16,
   parameter int OPC_W     = 7,
   parameter int IL_W      = 3,
   parameter int CNT_FLD_W = 2,
   parameter int BASE      = 5,
   parameter int IDX_W     = 4
) (
   input  logic [PW-1:0]    data,
   output logic             is_prefix,
   output logic             malformed,
   output logic [IDX_W-1:0] total,
   output logic [IDX_W-1:0] vl_end,
   output logic [IDX_W-1:0] rc_end,
   output logic [IDX_W-1:0] pc_end,
   output logic             no_pay
);
   localparam int VLF_POS = OPC_W;
   localparam int RC_POS  = VLF_POS + 1;
   localparam int PC_POS  = RC_POS + CNT_FLD_W;
   localparam int IL_POS  = PC_POS + CNT_FLD_W;
   localparam int RSV_POS = IL_POS + IL_W;

   generate
      if (RSV_POS > PW - 1) begin : g_bad_layout
         $error("header fields do not fit the parcel width");
      end
   endgenerate

   logic [IL_W-1:0]      il;
   logic [CNT_FLD_W-1:0] n_reg, n_pred;
   logic                 has_vl, rsv_set;

   always_comb begin
      il        = data[IL_POS +: IL_W];
      n_reg     = data[RC_POS +: CNT_FLD_W];
      n_pred    = data[PC_POS +: CNT_FLD_W];
      has_vl    = data[VLF_POS];
      rsv_set   = |data[PW-1:RSV_POS];
      is_prefix = &data[OPC_W-1:0];
      malformed = (&il) | rsv_set;
      total     = IDX_W'(BASE) + IDX_W'(il);
      vl_end    = IDX_W'(1) + IDX_W'(has_vl);
      rc_end    = vl_end + IDX_W'(n_reg);
      pc_end    = rc_end + IDX_W'(n_pred);
      no_pay    = (pc_end >= total);
   end
endmodule

// File: rtl/prs_seq.sv
module prs_seq
   import prs_pkg::*;
#(
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             xfer,
   input  logic [IDX_W-1:0] total,
   input  logic [IDX_W-1:0] vl_end,
   input  logic [IDX_W-1:0] rc_end,
   input  logic [IDX_W-1:0] pc_end,
   output logic             active,
   output logic             last,
   output ptag_e            tag
);
   logic [IDX_W-1:0] idx, total_q, vl_end_q, rc_end_q, pc_end_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active   <= 1'b0;
         idx      <= '0;
         total_q  <= '0;
         vl_end_q <= '0;
         rc_end_q <= '0;
         pc_end_q <= '0;
      end else if (start) begin
         active   <= 1'b1;
         idx      <= IDX_W'(1);
         total_q  <= total;
         vl_end_q <= vl_end;
         rc_end_q <= rc_end;
         pc_end_q <= pc_end;
      end else if (active && xfer) begin
         if (last) begin
            active <= 1'b0;
            idx    <= '0;
         end else begin
            idx <= idx + IDX_W'(1);
         end
      end
   end

   always_comb begin
      last = (idx == total_q - IDX_W'(1));
      if (idx < vl_end_q)      tag = TAG_VLB;
      else if (idx < rc_end_q) tag = TAG_REG;
      else if (idx < pc_end_q) tag = TAG_PRED;
      else                     tag = TAG_PAY;
   end

   // R3: the group position never runs past the group length
   a_r3_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (idx >= IDX_W'(1) && idx < total_q));

   // R10: no transfer, no advance
   a_r10_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !xfer) |=> (idx == $past(idx)));

   // R9: bounds stay ordered for the whole group
   a_r9_bounds_order: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (vl_end_q <= rc_end_q && rc_end_q <= pc_end_q));
endmodule

// File: rtl/prs_vl_latch.sv
module prs_vl_latch #(
   parameter int VLEN_W       = 6,
   parameter int MAXVL_W      = 6,
   parameter int SUBVL_W      = 3,
   parameter bit CLEAR_ON_END = 1'b1,
   localparam int IN_W        = VLEN_W + MAXVL_W + SUBVL_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic               clear,
   input  logic [IN_W-1:0]    data,
   output logic [VLEN_W-1:0]  vlen,
   output logic [MAXVL_W-1:0] maxvl,
   output logic [SUBVL_W-1:0] subvl
);
   localparam int MAX_POS = VLEN_W;
   localparam int SUB_POS = VLEN_W + MAXVL_W;

   generate
      if (CLEAR_ON_END) begin : g_clear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vlen  <= '0;
               maxvl <= '0;
               subvl <= '0;
            end else if (clear) begin
               vlen  <= '0;
               maxvl <= '0;
               subvl <= '0;
            end else if (load) begin
               vlen  <= data[0 +: VLEN_W];
               maxvl <= data[MAX_POS +: MAXVL_W];
               subvl <= data[SUB_POS +: SUBVL_W];
            end
         end
      end else begin : g_hold
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vlen  <= '0;
               maxvl <= '0;
               subvl <= '0;
            end else if (load || (clear && 1'b0)) begin
               vlen  <= data[0 +: VLEN_W];
               maxvl <= data[MAX_POS +: MAXVL_W];
               subvl <= data[SUB_POS +: SUBVL_W];
            end
         end
      end
   endgenerate

   // R4: latched lengths change only on a load or a clear
   a_r4_vl_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !clear) |=> ($stable(vlen) && $stable(maxvl) && $stable(subvl)));
endmodule

// File: rtl/vliw_grp_parser.sv
module vliw_grp_parser
   import prs_pkg::*;
#(
   parameter int PW           = 16,
   parameter int OPC_W        = 7,
   parameter int IL_W         = 3,
   parameter int CNT_FLD_W    = 2,
   parameter int BASE         = 5,
   parameter int VLEN_W       = 6,
   parameter int MAXVL_W      = 6,
   parameter int SUBVL_W      = 3,
   parameter bit CLEAR_ON_END = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [PW-1:0]      in_data,
   output logic               out_valid,
   input  logic               out_ready,
   output logic [PW-1:0]      out_data,
   output logic [2:0]         out_tag,
   output logic               grp_active,
   output logic               grp_end,
   output logic               err_hdr,
   output logic               err_nopay,
   output logic [VLEN_W-1:0]  vl_len,
   output logic [MAXVL_W-1:0] vl_max,
   output logic [SUBVL_W-1:0] vl_sub
);
   localparam int TOT_MAX = BASE + (2**IL_W) - 2;
   localparam int OVH_MAX = 2 + 2 * ((2**CNT_FLD_W) - 1);
   localparam int SPAN    = (TOT_MAX > OVH_MAX) ? TOT_MAX : OVH_MAX;
   localparam int IDX_W   = $clog2(SPAN + 1);
   localparam int VLB_W   = VLEN_W + MAXVL_W + SUBVL_W;

   generate
      if (VLB_W > PW) begin : g_bad_vlb
         $error("vector-length block fields exceed the parcel width");
      end
      if (IL_W < 1 || CNT_FLD_W < 1 || BASE < 2) begin : g_bad_param
         $error("field widths or base length out of range");
      end
   endgenerate

   logic             xfer, is_prefix, malformed, no_pay, start, last;
   logic [IDX_W-1:0] total, vl_end, rc_end, pc_end;
   ptag_e            seq_tag, tag;

   assign xfer      = in_valid & out_ready;
   assign in_ready  = out_ready;
   assign out_valid = in_valid;
   assign out_data  = in_data;

   prs_hdr_dec #(
      .PW(PW), .OPC_W(OPC_W), .IL_W(IL_W), .CNT_FLD_W(CNT_FLD_W),
      .BASE(BASE), .IDX_W(IDX_W)
   ) u_dec (
      .data(in_data), .is_prefix(is_prefix), .malformed(malformed),
      .total(total), .vl_end(vl_end), .rc_end(rc_end), .pc_end(pc_end),
      .no_pay(no_pay)
   );

   assign start = xfer & ~grp_active & is_prefix & ~malformed;

   prs_seq #(.IDX_W(IDX_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .xfer(xfer),
      .total(total), .vl_end(vl_end), .rc_end(rc_end), .pc_end(pc_end),
      .active(grp_active), .last(last), .tag(seq_tag)
   );

   always_comb begin
      if (grp_active)     tag = seq_tag;
      else if (is_prefix) tag = TAG_HDR;
      else                tag = TAG_INSN;
   end
   assign out_tag = tag;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grp_end   <= 1'b0;
         err_hdr   <= 1'b0;
         err_nopay <= 1'b0;
      end else begin
         grp_end   <= xfer & grp_active & last;
         err_hdr   <= xfer & ~grp_active & is_prefix & malformed;
         err_nopay <= start & no_pay;
      end
   end

   prs_vl_latch #(
      .VLEN_W(VLEN_W), .MAXVL_W(MAXVL_W), .SUBVL_W(SUBVL_W),
      .CLEAR_ON_END(CLEAR_ON_END)
   ) u_vl (
      .clk(clk), .rst_n(rst_n),
      .load(xfer & grp_active & (seq_tag == TAG_VLB)),
      .clear(xfer & grp_active & last),
      .data(in_data[VLB_W-1:0]),
      .vlen(vl_len), .maxvl(vl_max), .subvl(vl_sub)
   );

   // R3: the end pulse goes with leaving the group
   a_r3_end_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(grp_active) |-> grp_end);
   a_r3_end_outside: assert property (@(posedge clk) disable iff (!rst_n)
      grp_end |-> !grp_active);
   a_r3_end_single: assert property (@(posedge clk) disable iff (!rst_n)
      grp_end |=> !grp_end);
   // R8: a malformed prefix never opens a group
   a_r8_bad_no_group: assert property (@(posedge clk) disable iff (!rst_n)
      err_hdr |-> !grp_active);
   // R9: the no-payload flag only follows a group that did open
   a_r9_nopay_in_grp: assert property (@(posedge clk) disable iff (!rst_n)
      err_nopay |-> grp_active);
   // R11: lengths read zero when the group closes
   a_r11_clear_on_end: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_end && CLEAR_ON_END) |-> (vl_len == '0 && vl_max == '0 && vl_sub == '0));
endmodule

// File: tb/sim_vliw_grp_parser.sv
module sim_vliw_grp_parser;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        out_ready = 1'b0;
   logic [15:0] in_data = '0;
   logic        in_ready, out_valid, grp_active, grp_end, err_hdr, err_nopay;
   logic [15:0] out_data;
   logic [2:0]  out_tag;
   logic [5:0]  vl_len, vl_max;
   logic [2:0]  vl_sub;

   always #2 clk = ~clk;

   vliw_grp_parser u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .out_tag(out_tag), .grp_active(grp_active),
      .grp_end(grp_end), .err_hdr(err_hdr), .err_nopay(err_nopay),
      .vl_len(vl_len), .vl_max(vl_max), .vl_sub(vl_sub)
   );

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   // reference model state
   int m_act = 0, m_idx = 0, m_tot = 0, m_ve = 0, m_re = 0, m_pe = 0;
   int e_vlen = 0, e_vmax = 0, e_vsub = 0;
   bit e_end = 0, e_eh = 0, e_en = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int exp_tag(input logic [15:0] d);
      if (m_act == 0) return (d[6:0] == 7'h7F) ? 1 : 0;
      if (m_idx < m_ve) return 2;
      if (m_idx < m_re) return 3;
      if (m_idx < m_pe) return 4;
      return 5;
   endfunction

   function automatic string tag_req(input int t);
      case (t)
         0: return "R1";
         1: return "R2";
         2: return "R4";
         3: return "R5";
         4: return "R6";
         default: return "R7";
      endcase
   endfunction

   function automatic logic [15:0] hdr(input int il, input int vb, input int rc, input int pc);
      return {1'b0, il[2:0], pc[1:0], rc[1:0], vb[0], 7'h7F};
   endfunction

   task automatic check_regs();
      chk(grp_active == (m_act != 0), "R3", "grp_active", grp_active, m_act);
      chk(grp_end == e_end, "R3", "grp_end", grp_end, e_end);
      chk(err_hdr == e_eh, "R8", "err_hdr", err_hdr, e_eh);
      chk(err_nopay == e_en, "R9", "err_nopay", err_nopay, e_en);
      chk(vl_len == e_vlen[5:0], "R4", "vl_len", vl_len, e_vlen);
      chk(vl_max == e_vmax[5:0], "R4", "vl_max", vl_max, e_vmax);
      chk(vl_sub == e_vsub[2:0], "R11", "vl_sub", vl_sub, e_vsub);
   endtask

   task automatic step(input bit v, input logic [15:0] d, input bit rdy);
      int t;
      @(negedge clk);
      in_valid = v; in_data = d; out_ready = rdy;
      #1;
      chk(out_valid == v, "R1", "out_valid", out_valid, v);
      chk(in_ready == rdy, "R10", "in_ready", in_ready, rdy);
      chk(out_data == d, "R1", "out_data", out_data, d);
      t = exp_tag(d);
      if (v) chk(out_tag == t[2:0], tag_req(t), "out_tag", out_tag, t);
      e_end = 0; e_eh = 0; e_en = 0;
      if (v && rdy) begin
         if (m_act == 0) begin
            if (d[6:0] == 7'h7F) begin
               if (d[14:12] == 3'b111 || d[15]) e_eh = 1;
               else begin
                  m_act = 1; m_idx = 1;
                  m_tot = 5 + int'(d[14:12]);
                  m_ve  = 1 + int'(d[7]);
                  m_re  = m_ve + int'(d[9:8]);
                  m_pe  = m_re + int'(d[11:10]);
                  if (m_pe >= m_tot) e_en = 1;
               end
            end
         end else begin
            if (t == 2) begin
               e_vlen = int'(d[5:0]); e_vmax = int'(d[11:6]); e_vsub = int'(d[14:12]);
            end
            if (m_idx == m_tot - 1) begin
               m_act = 0; m_idx = 0; e_end = 1;
               e_vlen = 0; e_vmax = 0; e_vsub = 0;
            end else m_idx++;
         end
      end
      @(posedge clk);
      #1;
      check_regs();
   endtask

   task automatic send(input logic [15:0] d);
      step(1'b1, d, 1'b1);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(4 * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finish_run();
   end

   initial begin
      void'($urandom(32'd4099));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R12: reset state
      chk(grp_active == 0 && grp_end == 0, "R12", "group flags", grp_active, 0);
      chk(err_hdr == 0 && err_nopay == 0, "R12", "error flags", err_hdr, 0);
      chk(vl_len == 0 && vl_max == 0 && vl_sub == 0, "R12", "vl outputs", vl_len, 0);
      chk(out_tag == 3'd0, "R12", "idle tag", out_tag, 0);

      // R1: plain instructions
      send(16'h1234);
      send(16'h00FE);
      // R2 R4 R5 R6 R7 R10: full group with a stall and a bubble
      send(hdr(1, 1, 1, 1));
      send(16'h3A85);
      step(1'b1, 16'h4111, 1'b0);   // R10 stalled REGCAM
      send(16'h4111);
      step(1'b0, 16'h0000, 1'b1);
      send(16'h5222);
      send(16'h007F);               // R7 prefix-looking payload
      send(16'h0013);
      send(16'h0033);               // R1 back outside
      // R11: group without VL block, lengths stay zero
      send(hdr(0, 0, 0, 0));
      repeat (4) send(16'h0AFF);
      // R8: malformed prefixes
      send(hdr(7, 0, 0, 0));
      send(16'h0001);
      send(hdr(1, 0, 0, 0) | 16'h8000);
      send(16'h007F | 16'h1000);    // valid IL=1 prefix opens a group
      repeat (5) send(16'h0101);
      // R9: no payload room
      send(hdr(0, 1, 3, 3));
      send(16'h7FFF);
      send(16'h0002); send(16'h0003); send(16'h0004);
      send(16'h0005);
      // random mix
      for (int i = 0; i < 6000; i++) begin
         logic [15:0] d;
         bit v, r;
         v = ($urandom % 5) != 0;
         r = ($urandom % 4) != 0;
         d = 16'($urandom);
         if (($urandom % 4) == 0) begin
            d[6:0] = 7'h7F;
            if (($urandom % 8) != 0) d[15] = 1'b0;
         end
         step(v, d, r);
      end
      finish_run();
   end
endmodule